// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block supervises a host processor. The host programs an enable bit and a 5-bit timeout setting. Each unit of the setting is 60 ms. The host then keeps the watchdog alive by writing one fixed 4-bit restart key before the window runs out. If the window expires first, the block drives an active-low reset for 100 ms and records that the watchdog caused the reset. At the end of that pulse the block reloads itself and starts counting again.

The time base is a prescaler. It divides the system clock into 1 ms ticks, and both the window counter and the pulse counter count those ticks. When the enable bit is clear, the counters still run and still expire, but the reset output stays high. A new timeout setting only applies when the window is next reloaded, either by a valid restart or at the end of a pulse. The host clears the reset-source flag by writing a one to a clear strobe.

Top module: `wdt_keyed_supervisor`

## Requirements
- R1: Writing the restart field with the key value 4'b1010 reloads the window to its full length. A restart write with any other value leaves the running count unchanged.
- R2: The window lasts max(setting,1) × STEP_MS ticks of 1 ms, and each tick is CLK_PER_MS clock cycles. The window starts at the clock edge that accepts the restart.
- R3: When the window expires with the enable bit set, `wdt_rst_n` is low for exactly PULSE_MS ms (100 ms by default), starting the cycle after the expiring edge.
- R4: With the enable bit clear, the window still counts, expires and runs through a pulse interval, but `wdt_rst_n` stays high and the flag is not set.
- R5: At the end of a pulse interval, the window reloads from the current setting and the next expiry follows one full window later.
- R6: `src_flag` becomes 1 together with a watchdog reset. A `flag_clr_we` strobe clears it, and if both happen in the same cycle, the set wins.
- R7: Writing a new setting does not reload the count in progress. The new value applies at the next restart or pulse-end reload.
- R8: A setting of 0 gives a window of one 60 ms step and never an immediate expiry.
- R9: A restart write with the correct key during a pulse interval is ignored and does not shorten or extend the pulse.
- R10: After `rst_n` is released, `wdt_rst_n` is 1 and `src_flag` is 0. The enable bit and the setting are both 0, and a one-step window is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the enable bit and the timeout setting |
| cfg_enable | input | 1 | Enable bit that allows the reset output to be driven |
| cfg_steps | input | STEPS_W | Timeout setting in 60 ms steps |
| key_we | input | 1 | Write strobe for the restart field |
| key_val | input | 4 | Restart field value; 4'b1010 is the key |
| flag_clr_we | input | 1 | Write-one strobe that clears the reset-source flag |
| wdt_rst_n | output | 1 | Active-low reset to the host |
| src_flag | output | 1 | The most recent reset came from the watchdog |

## Verification
The bench model counts in raw clock cycles. A valid restart accepted at edge E schedules expiry at edge E + W·CLK_PER_MS. The output falls after that edge and rises again 100·CLK_PER_MS edges later, and the flag changes at the same edge as the pulse start or the clear strobe. Inputs are driven and outputs compared on falling edges, so every result is compared in the first half-cycle in which it is due.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam logic [3:0] RESTART_KEY = 4'b1010;
   typedef enum logic {PH_RUN = 1'b0, PH_PULSE = 1'b1} wdt_phase_e;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
   parameter int CLK_PER_MS = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (CLK_PER_MS < 1) begin : g_bad
         $error("wdt_tick_gen: CLK_PER_MS must be at least 1");
      end
      if (CLK_PER_MS == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(CLK_PER_MS);
         localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);
         logic [PW-1:0] phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          phase_q <= '0;
            else if (clr || (phase_q == LAST))   phase_q <= '0;
            else                                 phase_q <= phase_q + 1'b1;
         end
         assign tick = (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdt_window_ctr.sv
module wdt_window_ctr #(
   parameter int CW       = 11,
   parameter int RST_LOAD = 60
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          run,
   input  logic          restart,
   input  logic          pulse_done,
   input  logic [CW-1:0] reload_val,
   output logic          expire
);
   logic [CW-1:0] wcnt_q;
   logic          load;

   assign load   = restart | pulse_done;
   assign expire = run & tick & ~restart & (wcnt_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              wcnt_q <= CW'(RST_LOAD);
      else if (load)                           wcnt_q <= reload_val;
      else if (run && tick && wcnt_q != CW'(1)) wcnt_q <= wcnt_q - 1'b1;
   end

   a_r1_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(wcnt_q));
   a_r5_reload_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_done |=> (wcnt_q == $past(reload_val)));
   a_r8_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt_q != '0);
endmodule

// File: rtl/wdt_pulse_ctr.sv
module wdt_pulse_ctr #(
   parameter int PULSE_MS = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start,
   input  logic active,
   output logic done
);
   localparam int PCW = $clog2(PULSE_MS + 1);
   logic [PCW-1:0] pcnt_q;

   assign done = active & tick & (pcnt_q == PCW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pcnt_q <= '0;
      else if (start)             pcnt_q <= PCW'(PULSE_MS);
      else if (active && tick)    pcnt_q <= pcnt_q - 1'b1;
   end

   a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (pcnt_q != '0));
endmodule

// File: rtl/wdt_keyed_supervisor.sv
module wdt_keyed_supervisor
   import wdt_pkg::*;
#(
   parameter int CLK_PER_MS = 50000,
   parameter int STEP_MS    = 60,
   parameter int PULSE_MS   = 100,
   parameter int STEPS_W    = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_enable,
   input  logic [STEPS_W-1:0] cfg_steps,
   input  logic               key_we,
   input  logic [3:0]         key_val,
   input  logic               flag_clr_we,
   output logic               wdt_rst_n,
   output logic               src_flag
);
   localparam int WIN_MAX = ((1 << STEPS_W) - 1) * STEP_MS;
   localparam int CW      = $clog2(WIN_MAX + 1);

   generate
      if (STEP_MS < 1 || PULSE_MS < 1 || STEPS_W < 1) begin : g_bad
         $error("wdt_keyed_supervisor: STEP_MS, PULSE_MS and STEPS_W must be positive");
      end
   endgenerate

   logic               en_q, drv_q, flag_q;
   logic [STEPS_W-1:0] steps_q;
   wdt_phase_e         phase_q;
   logic               tick, restart, expire, pulse_done, run;
   logic [CW-1:0]      reload_val;

   assign run        = (phase_q == PH_RUN);
   assign restart    = run & key_we & (key_val == RESTART_KEY);
   assign reload_val = ((steps_q == '0) ? CW'(1) : CW'(steps_q)) * CW'(STEP_MS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         steps_q <= '0;
      end else if (cfg_we) begin
         en_q    <= cfg_enable;
         steps_q <= cfg_steps;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_RUN;
         drv_q   <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         if (expire) begin
            phase_q <= PH_PULSE;
            drv_q   <= en_q;
         end else if (pulse_done) begin
            phase_q <= PH_RUN;
         end
         if (expire && en_q)   flag_q <= 1'b1;
         else if (flag_clr_we) flag_q <= 1'b0;
      end
   end

   wdt_tick_gen #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(restart), .tick(tick));

   wdt_window_ctr #(.CW(CW), .RST_LOAD(STEP_MS)) u_win (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .restart(restart),
      .pulse_done(pulse_done), .reload_val(reload_val), .expire(expire));

   wdt_pulse_ctr #(.PULSE_MS(PULSE_MS)) u_pulse (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(expire),
      .active(phase_q == PH_PULSE), .done(pulse_done));

   assign wdt_rst_n = ~((phase_q == PH_PULSE) & drv_q);
   assign src_flag  = flag_q;

   a_r3_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !tick) |=> !run);
   a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_q |-> wdt_rst_n);
   a_r6_flag_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdt_rst_n) |-> src_flag);
   a_r9_no_restart_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !tick) |=> $stable(wdt_rst_n));
endmodule

// File: tb/wdt_keyed_supervisor_tb_top.sv
module wdt_keyed_supervisor_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CPM  = 2;
   localparam int STEP = 60;
   localparam int PLS  = 100;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 0, cfg_enable = 0, key_we = 0, flag_clr_we = 0;
   logic [4:0] cfg_steps = '0;
   logic [3:0] key_val = '0;
   logic wdt_rst_n, src_flag;

   int checks = 0, fails = 0;
   string cur_req = "R10";

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_keyed_supervisor #(.CLK_PER_MS(CPM), .STEP_MS(STEP), .PULSE_MS(PLS), .STEPS_W(5)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
      .cfg_steps(cfg_steps), .key_we(key_we), .key_val(key_val),
      .flag_clr_we(flag_clr_we), .wdt_rst_n(wdt_rst_n), .src_flag(src_flag));

   // behavioural reference, counting raw clock cycles
   bit m_en, m_pulse, m_drv, m_flag;
   int m_steps, m_rem, m_plen;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = 0; m_steps = 0; m_rem = STEP*CPM; m_pulse = 0;
         m_plen = 0; m_drv = 0; m_flag = 0;
      end else begin
         int w;
         bit set;
         w = ((m_steps == 0) ? 1 : m_steps) * STEP * CPM;
         set = 0;
         if (m_pulse) begin
            m_plen--;
            if (m_plen == 0) begin m_pulse = 0; m_rem = w; end
         end else if (key_we && key_val == 4'b1010) begin
            m_rem = w;
         end else begin
            m_rem--;
            if (m_rem == 0) begin
               m_pulse = 1; m_plen = PLS*CPM; m_drv = m_en; set = m_en;
            end
         end
         if (set) m_flag = 1;
         else if (flag_clr_we) m_flag = 0;
         if (cfg_we) begin m_en = cfg_enable; m_steps = int'(cfg_steps); end
      end
   end

   always @(negedge clk) begin
      bit exp_rst_n;
      exp_rst_n = !(m_pulse && m_drv);
      checks++;
      if (wdt_rst_n !== exp_rst_n || src_flag !== m_flag) begin
         fails++;
         $display("FAIL %s: wdt_rst_n=%b src_flag=%b expected wdt_rst_n=%b src_flag=%b at %0t",
                  cur_req, wdt_rst_n, src_flag, exp_rst_n, m_flag, $time);
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic wr_key(logic [3:0] v);
      @(negedge clk); key_we = 1; key_val = v;
      @(negedge clk); key_we = 0;
   endtask
   task automatic wr_cfg(logic en, logic [4:0] s);
      @(negedge clk); cfg_we = 1; cfg_enable = en; cfg_steps = s;
      @(negedge clk); cfg_we = 0;
   endtask
   task automatic clr_flag();
      @(negedge clk); flag_clr_we = 1;
      @(negedge clk); flag_clr_we = 0;
   endtask

   bit done = 0;
   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      cur_req = "R10";
      idle(3);
      rst_n = 1'b1;
      idle(5);
      cur_req = "R4";           // disabled: expiries at 120/440, output stays high
      idle(500);
      cur_req = "R8";           // enable with zero setting, no restart: next expiry from the running count
      wr_cfg(1'b1, 5'd0);
      idle(300);
      cur_req = "R1";           // 2 steps, repeated good restarts
      wr_cfg(1'b1, 5'd2);
      wr_key(4'b1010);
      for (int i = 0; i < 5; i++) begin idle(200); wr_key(4'b1010); end
      for (int i = 0; i < 3; i++) begin idle(60); wr_key(4'(5 + 6*i)); end
      cur_req = "R3";
      idle(100);
      cur_req = "R9";
      wr_key(4'b1010);
      idle(50);
      wr_key(4'b1010);
      cur_req = "R5";
      idle(400);
      cur_req = "R6";
      clr_flag();
      idle(20);
      cur_req = "R7";
      wr_key(4'b1010);
      idle(10);
      wr_cfg(1'b1, 5'd1);
      idle(700);
      cur_req = "R2";
      wr_cfg(1'b1, 5'd3);
      wr_key(4'b1010);
      idle(600);
      cur_req = "R8";
      wr_cfg(1'b1, 5'd0);
      wr_key(4'b1010);
      idle(400);
      cur_req = "R6";
      clr_flag();
      idle(10);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule